// File: doc/BRIEF.md
# Monitoring Token FIFO with Threshold, Swap and Rate Measurement

This block is a single-clock first-in first-out queue for control tokens, sized by default at sixteen 16-bit entries. Beyond ordinary push and pop, it reports its occupancy on every cycle and raises a level flag once that occupancy reaches a programmable threshold. On command it exchanges two stored entries in place. It also measures how many tokens arrived during each window of a programmable number of cycles, and reports that count together with its signed change from the previous window.

The read side is show-ahead: the oldest entry is always present on the read data output while the queue is non-empty, and a read request removes it. A swap names two positions counted from the head (position 0 is the entry on the read data output). It is honoured only on a cycle with no push or pop request, and only when both positions hold data.

The rate monitor is a two-state machine. `RS_FIRST` covers the first window after reset or after a window-length change, when no previous rate exists yet. `RS_RUN` covers every later window. It moves `RS_FIRST -> RS_RUN` when a window ends and stays in `RS_RUN` on `RS_RUN -> RS_RUN`. A change of the window-length input forces `RS_FIRST -> RS_FIRST` or `RS_RUN -> RS_FIRST` as a restart. The queue side has no stored state machine. A per-cycle operation select (`OP_IDLE`, `OP_PUSH`, `OP_POP`, `OP_XFER`, `OP_SWAP`, `OP_REJECT`) decides what the registers do on each edge.

Top module: `mon_fifo`

## Requirements
- R1: Entries leave in the order they were accepted. While `empty` is low, `rd_data` shows the oldest entry, and a value pushed on an empty queue appears there one cycle later.
- R2: A cycle with `wr_en` and `rd_en` both high on a non-empty queue, including a full one, removes the head and appends the new word, leaving `count` unchanged.
- R3: `count` gives the number of stored entries (0 to 16, five bits). `full` is high exactly when `count` is 16 and `empty` exactly when it is 0. All three update one cycle after the accepting edge.
- R4: A write on a full queue without a read is ignored. A read on an empty queue is ignored; with a write on the same cycle, only the write takes effect.
- R5: `thresh_hit` is high whenever `count >= cfg_thresh` (a threshold of 0 keeps it high).
- R6: An accepted swap exchanges the entries at head-relative positions `swap_a` and `swap_b` in one cycle and leaves `count` unchanged. Equal positions are a no-op.
- R7: A swap request is refused if `swap_a` or `swap_b` is not below `count`, or if `wr_en` or `rd_en` is high in that cycle. A refused swap changes no entry and gives a one-cycle `swap_err` pulse on the next cycle.
- R8: With window length L = `cfg_window` (0 treated as 1), the block counts the writes accepted in each run of L cycles. On the cycle after the last cycle of a window, `rate_valid` pulses for one cycle and `rate` holds that count.
- R9: Together with `rate`, `rate_delta` gives the 17-bit two's-complement value `rate` minus the previous window's rate. The first window after a restart subtracts 0.
- R10: When `cfg_window` differs from its value on the previous cycle (taken as 0 just after reset), the window restarts. The cycle counter, the arrival count and the previous rate clear, the writes of that cycle are not counted, and the monitor returns to `RS_FIRST`.
- R11: After reset, `count` is 0, `empty` is high, `full`, `swap_err` and `rate_valid` are low, and `rate` and `rate_delta` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Push request |
| wr_data | input | 16 | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 16 | Head entry (show-ahead) |
| full | output | 1 | Queue holds 16 entries |
| empty | output | 1 | Queue holds no entry |
| count | output | 5 | Current occupancy |
| cfg_thresh | input | 5 | Occupancy threshold |
| thresh_hit | output | 1 | Occupancy at or above threshold |
| swap_req | input | 1 | Swap command |
| swap_a | input | 4 | First head-relative position |
| swap_b | input | 4 | Second head-relative position |
| swap_err | output | 1 | Refused-swap pulse |
| cfg_window | input | 16 | Window length in cycles |
| rate_valid | output | 1 | Window-end pulse |
| rate | output | 16 | Writes accepted in the last complete window |
| rate_delta | output | 17 | Signed change of `rate` from the window before |

## Verification
Queue contents, `count`, `full`, `empty` and `swap_err` are due one cycle after the edge that samples the request. `thresh_hit` follows `count` with no further delay, and the window results are due one cycle after a window's last cycle. The bench's reference model applies each edge's inputs at that edge and compares every output 1 ns after the same edge. Each result is therefore checked in the first cycle it is due and in every cycle after. Inputs change only on falling edges.

// File: rtl/mon_fifo_pkg.sv
package mon_fifo_pkg;

    // Per-cycle queue operation chosen by the controller
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_XFER,
        OP_SWAP,
        OP_REJECT
    } queue_op_e;

    // Rate monitor states
    typedef enum logic {
        RS_FIRST,
        RS_RUN
    } rate_state_e;

endpackage

// File: rtl/mon_fifo_ctrl.sv
module mon_fifo_ctrl
    import mon_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             swap_req,
    input  logic [AW-1:0]    swap_a,
    input  logic [AW-1:0]    swap_b,
    output logic             do_push,
    output logic             do_pop,
    output logic             do_swap,
    output logic [CNT_W-1:0] count,
    output logic             swap_err
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    queue_op_e op;
    logic      push_ok;
    logic      pop_ok;
    logic      swap_ok;

    always_comb begin
        push_ok = wr_en && ((count != FULL_CNT) || rd_en);
        pop_ok  = rd_en && (count != '0);
        swap_ok = swap_req && !wr_en && !rd_en
                  && ({1'b0, swap_a} < count) && ({1'b0, swap_b} < count);
        if (swap_ok)
            op = OP_SWAP;
        else if (swap_req)
            op = OP_REJECT;
        else if (push_ok && pop_ok)
            op = OP_XFER;
        else if (push_ok)
            op = OP_PUSH;
        else if (pop_ok)
            op = OP_POP;
        else
            op = OP_IDLE;
    end

    // A refused swap still lets a legal push or pop through
    always_comb begin
        do_push = 1'b0;
        do_pop  = 1'b0;
        do_swap = 1'b0;
        unique case (op)
            OP_IDLE:   ;
            OP_PUSH:   do_push = 1'b1;
            OP_POP:    do_pop  = 1'b1;
            OP_XFER:   begin do_push = 1'b1; do_pop = 1'b1; end
            OP_SWAP:   do_swap = 1'b1;
            OP_REJECT: begin do_push = push_ok; do_pop = pop_ok; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            swap_err <= 1'b0;
        end else begin
            swap_err <= (op == OP_REJECT);
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/mon_fifo_store.sv
module mon_fifo_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_push,
    input  logic              do_pop,
    input  logic              do_swap,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     swap_a,
    input  logic [AW-1:0]     swap_b,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [AW-1:0]     slot_a;
    logic [AW-1:0]     slot_b;

    // Head-relative positions wrap with the pointers (DEPTH is a power of two)
    assign slot_a  = rd_ptr + swap_a;
    assign slot_b  = rd_ptr + swap_b;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[i] <= '0;
                else if (do_swap && (slot_a == AW'(i)))
                    mem[i] <= mem[slot_b];
                else if (do_swap && (slot_b == AW'(i)))
                    mem[i] <= mem[slot_a];
                else if (do_push && (wr_ptr == AW'(i)))
                    mem[i] <= wr_data;
            end
        end
    endgenerate

endmodule

// File: rtl/mon_fifo_rate.sv
module mon_fifo_rate
    import mon_fifo_pkg::*;
#(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arrival,
    input  logic [WIN_W-1:0] cfg_window,
    output logic             rate_valid,
    output logic [WIN_W-1:0] rate,
    output logic [WIN_W:0]   rate_delta
);

    rate_state_e       state;
    rate_state_e       state_nxt;
    logic [WIN_W-1:0]  cfg_q;
    logic [WIN_W-1:0]  cyc;
    logic [WIN_W-1:0]  acc;
    logic [WIN_W-1:0]  prev;
    logic [WIN_W-1:0]  last_idx;
    logic [WIN_W-1:0]  sum;
    logic              restart;
    logic              at_end;

    always_comb begin
        last_idx = (cfg_window == '0) ? '0 : cfg_window - 1'b1;
        restart  = (cfg_window != cfg_q);
        at_end   = !restart && (cyc == last_idx);
        sum      = acc + WIN_W'(arrival);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RS_FIRST: if (at_end) state_nxt = RS_RUN;
            RS_RUN:   state_nxt = RS_RUN;
            default:  state_nxt = RS_FIRST;
        endcase
        if (restart)
            state_nxt = RS_FIRST;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RS_FIRST;
        else
            state <= state_nxt;
    end

    // Window counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cyc   <= '0;
            acc   <= '0;
            prev  <= '0;
        end else begin
            cfg_q <= cfg_window;
            if (restart) begin
                cyc  <= '0;
                acc  <= '0;
                prev <= '0;
            end else if (at_end) begin
                cyc  <= '0;
                acc  <= '0;
                prev <= sum;
            end else begin
                cyc <= cyc + 1'b1;
                acc <= sum;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_valid <= 1'b0;
            rate       <= '0;
            rate_delta <= '0;
        end else begin
            rate_valid <= at_end;
            if (at_end) begin
                rate <= sum;
                rate_delta <= {1'b0, sum}
                              - ((state == RS_FIRST) ? {(WIN_W+1){1'b0}} : {1'b0, prev});
            end
        end
    end

endmodule

// File: rtl/mon_fifo.sv
module mon_fifo
    import mon_fifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int WIN_W  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  cfg_thresh,
    output logic              thresh_hit,
    input  logic              swap_req,
    input  logic [AW-1:0]     swap_a,
    input  logic [AW-1:0]     swap_b,
    output logic              swap_err,
    input  logic [WIN_W-1:0]  cfg_window,
    output logic              rate_valid,
    output logic [WIN_W-1:0]  rate,
    output logic [WIN_W:0]    rate_delta
);

    logic do_push;
    logic do_pop;
    logic do_swap;

    mon_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .swap_req (swap_req),
        .swap_a   (swap_a),
        .swap_b   (swap_b),
        .do_push  (do_push),
        .do_pop   (do_pop),
        .do_swap  (do_swap),
        .count    (count),
        .swap_err (swap_err)
    );

    mon_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_push (do_push),
        .do_pop  (do_pop),
        .do_swap (do_swap),
        .wr_data (wr_data),
        .swap_a  (swap_a),
        .swap_b  (swap_b),
        .rd_data (rd_data)
    );

    mon_fifo_rate #(.WIN_W(WIN_W)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .arrival    (do_push),
        .cfg_window (cfg_window),
        .rate_valid (rate_valid),
        .rate       (rate),
        .rate_delta (rate_delta)
    );

    assign full       = (count == CNT_W'(DEPTH));
    assign empty      = (count == '0);
    assign thresh_hit = (count >= cfg_thresh);

endmodule

// File: rtl/mon_fifo_chk.sv
module mon_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             swap_req,
    input logic             full,
    input logic             empty,
    input logic [CNT_W-1:0] count,
    input logic             swap_err,
    input logic             rate_valid
);

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + CNT_W'(1))
                 || (count == $past(count) - CNT_W'(1)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !rd_en |=> full);

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty && rd_en && !wr_en |=> empty);

    // R2
    xfer_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !empty && wr_en && rd_en |=> $stable(count));

    // R6
    swap_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_req && !wr_en && !rd_en |=> $stable(count));

    // R7
    swap_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_req && (wr_en || rd_en) |=> swap_err);

    // R7
    swap_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_req |=> !swap_err);

    // R8
    rate_valid_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(rate_valid));

endmodule

bind mon_fifo mon_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .swap_req   (swap_req),
    .full       (full),
    .empty      (empty),
    .count      (count),
    .swap_err   (swap_err),
    .rate_valid (rate_valid)
);

// File: tb/mon_fifo_bench.sv
`timescale 1ns/1ps
module mon_fifo_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        full;
    logic        empty;
    logic [4:0]  count;
    logic [4:0]  cfg_thresh = 5'd4;
    logic        thresh_hit;
    logic        swap_req = 1'b0;
    logic [3:0]  swap_a = '0;
    logic [3:0]  swap_b = '0;
    logic        swap_err;
    logic [15:0] cfg_window = 16'd8;
    logic        rate_valid;
    logic [15:0] rate;
    logic [16:0] rate_delta;

    mon_fifo u_mon_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
        .count(count), .cfg_thresh(cfg_thresh), .thresh_hit(thresh_hit),
        .swap_req(swap_req), .swap_a(swap_a), .swap_b(swap_b),
        .swap_err(swap_err), .cfg_window(cfg_window), .rate_valid(rate_valid),
        .rate(rate), .rate_delta(rate_delta)
    );

    always #2.5 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R11 reset";
    bit    done     = 1'b0;
    int    neg_seen = 0;
    int    pulses   = 0;

    // Reference model state
    int m_q[$];
    bit m_err, m_rv;
    int m_rate, m_delta, m_cyc, m_acc, m_prev, m_cfgq;
    bit m_first;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] act=%0d exp=%0d at %0t", req, phase, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_err = 0; m_rv = 0; m_rate = 0; m_delta = 0;
            m_cyc = 0; m_acc = 0; m_prev = 0; m_cfgq = 0; m_first = 1;
        end else begin
            int sz, len, sum, tmp;
            bit push, pop, sw_ok;
            sz    = m_q.size();
            push  = wr_en && (sz < 16 || rd_en);
            pop   = rd_en && sz > 0;
            sw_ok = swap_req && !wr_en && !rd_en && int'(swap_a) < sz && int'(swap_b) < sz;
            m_err = swap_req && !sw_ok;
            if (sw_ok) begin
                tmp = m_q[swap_a];
                m_q[swap_a] = m_q[swap_b];
                m_q[swap_b] = tmp;
            end
            if (pop)  void'(m_q.pop_front());
            if (push) m_q.push_back(int'(wr_data));
            len = (cfg_window == 0) ? 1 : int'(cfg_window);
            m_rv = 0;
            if (int'(cfg_window) != m_cfgq) begin
                m_cyc = 0; m_acc = 0; m_prev = 0; m_first = 1;
            end else begin
                sum = m_acc + (push ? 1 : 0);
                if (m_cyc == len - 1) begin
                    m_rv = 1;
                    m_rate = sum;
                    m_delta = sum - (m_first ? 0 : m_prev);
                    m_prev = sum; m_first = 0; m_cyc = 0; m_acc = 0;
                end else begin
                    m_acc = sum; m_cyc++;
                end
            end
            m_cfgq = int'(cfg_window);
        end
        #1;
        if (rst_n) begin
            chk(int'(count) == m_q.size(), "R3 count", count, m_q.size());
            chk(full == (m_q.size() == 16), "R3 full", full, m_q.size() == 16);
            chk(empty == (m_q.size() == 0), "R3 empty", empty, m_q.size() == 0);
            chk(thresh_hit == (m_q.size() >= int'(cfg_thresh)), "R5 thresh_hit",
                thresh_hit, m_q.size() >= int'(cfg_thresh));
            if (m_q.size() > 0)
                chk(int'(rd_data) == m_q[0], "R1 head data", rd_data, m_q[0]);
            chk(swap_err == m_err, "R7 swap_err", swap_err, m_err);
            chk(rate_valid == m_rv, "R8 rate_valid", rate_valid, m_rv);
            if (m_rv) begin
                pulses++;
                chk(int'(rate) == m_rate, "R8 rate", rate, m_rate);
                chk(int'($signed(rate_delta)) == m_delta, "R9 rate_delta",
                    int'($signed(rate_delta)), m_delta);
                if (m_delta < 0) neg_seen++;
            end
        end
    end

    task automatic cyc(input bit w, input int d, input bit r,
                       input bit s = 0, input int a = 0, input int b = 0);
        @(negedge clk);
        wr_en = w; wr_data = 16'(d); rd_en = r;
        swap_req = s; swap_a = 4'(a); swap_b = 4'(b);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R11 reset state at the ports
        chk(count == 0 && empty && !full, "R11 queue reset", count, 0);
        chk(!swap_err && !rate_valid && rate == 0 && rate_delta == 0,
            "R11 monitor reset", rate, 0);

        phase = "R1 fill";
        for (int i = 0; i < 16; i++) cyc(1, 16'hA000 + i, 0);
        phase = "R4 write on full";
        cyc(1, 16'hDEAD, 0); cyc(1, 16'hBEEF, 0);
        phase = "R2 read+write on full";
        for (int i = 0; i < 3; i++) cyc(1, 16'hB000 + i, 1);
        phase = "R6 swap";
        cyc(0, 0, 0, 1, 0, 15);
        cyc(0, 0, 0, 1, 3, 7);
        cyc(0, 0, 0, 1, 5, 5);
        idle(1);
        phase = "R7 swap refused";
        for (int i = 0; i < 4; i++) cyc(0, 0, 1);
        cyc(0, 0, 0, 1, 13, 2);
        cyc(0, 0, 0, 1, 1, 12);
        cyc(1, 16'hC001, 0, 1, 0, 1);
        cyc(0, 0, 1, 1, 0, 1);
        idle(1);
        phase = "R5 threshold";
        cfg_thresh = 5'd0; idle(1);
        cfg_thresh = 5'd16; idle(1);
        cfg_thresh = 5'd12; idle(1);
        phase = "R1 drain";
        for (int i = 0; i < 15; i++) cyc(0, 0, 1);
        phase = "R4 read on empty";
        cyc(0, 0, 1); cyc(0, 0, 1);
        cyc(1, 16'h5A5A, 1);
        cyc(0, 0, 1);
        phase = "R8 window 8";
        for (int i = 0; i < 40; i++) cyc(i % 3 != 0, i, i % 2 == 0);
        phase = "R10 window change";
        cyc(1, 1, 1); cfg_window = 16'd5;
        for (int i = 0; i < 23; i++) cyc(1, i, 1);
        cfg_window = 16'd0;
        for (int i = 0; i < 6; i++) cyc(i % 2 == 0, i, 1);
        cfg_window = 16'd20;
        for (int i = 0; i < 10; i++) cyc(1, i, 1);
        cfg_window = 16'd6;
        phase = "R9 random traffic";
        for (int i = 0; i < 600; i++) begin
            int dens;
            dens = ((i / 30) % 2 == 0) ? 90 : 15;
            cyc($urandom_range(99) < dens, int'($urandom_range(65535)),
                $urandom_range(99) < 50,
                $urandom_range(99) < 8, int'($urandom_range(15)),
                int'($urandom_range(15)));
            if (i % 97 == 0) cfg_thresh = 5'($urandom_range(16));
        end
        idle(8);
        phase = "R9 sign";
        chk(neg_seen > 0, "R9 negative delta seen", neg_seen, 1);
        chk(pulses > 20, "R8 window pulses", pulses, 21);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule